// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Controller

This block lets a local requester run single read or write transfers on an asynchronous, interlocked backplane bus. Address and data share the same 18 lines. The address goes out first. Data moves after that, under a read or write strobe. Every strobe the master raises has to be answered by a reply from the slave, and the master takes its strobes down only after that reply. The bus has no clock of its own. The controller runs on a local clock and brings the asynchronous reply into that clock domain through two flip-flops.

All bus lines are active-low and open-collector. For each line the block drives a level output together with a drive-enable, and a line that is not pulled floats high. In the data phase the two upper lines take on a second use. On a read, the master pulls the top line to enable error reporting, and the slave can pull the line below it to flag a memory error. A timeout measured in local clock cycles ends any transfer the slave fails to finish. It releases every line and reports a bus error. The select for the top 8 KB bank is held off for as long as the refresh input is asserted.

Top module: `async_bus_master`

## Requirements
- R1: After reset, every drive-enable output is 0, `done` is 0 and `ack_n` is treated as released.
- R2: For a transfer, the address is placed active-low on all 18 lines (a line pulled low means a 1 bit) for SETUP_CYC cycles without the address strobe. The strobe is then added for HOLD_CYC more cycles with the address still driven. On a write, the write-indicator line is pulled during this phase.
- R3: In the data phase of a read, lines 15:0 are released, line 17 is pulled low as the error enable, the read strobe is pulled, and `rdata` receives the inverted levels of lines 15:0 when the synchronized reply is seen.
- R4: In the data phase of a write, `req_wdata` is driven active-low on lines 15:0 with the write strobe pulled, and lines 17:16 are released.
- R5: The data strobe stays on until the reply is seen. The address strobe stays on until the reply is released. `done` then pulses for exactly one cycle with the result. The read and write strobes are never on together, and neither is on without the address strobe.
- R6: `ack_n` passes through a two-flop synchronizer. A data strobe is seen still on at exactly two sampling points after the reply is asserted, and off at the third.
- R7: A transfer still running TMO_CYC = CLK_HZ·TMO_NS/10^9 cycles (1250 by default, which is 10 µs at 125 MHz) after it started is aborted. All lines are released, and `done` comes with `timeout_err`=1, `rdata`=0 and `mem_err`=0.
- R8: `mem_err` is 1 only for a completed read in which line 16 was low when the reply was seen. On writes, line 16 is ignored and `mem_err` is 0.
- R9: The top-bank select is pulled during the address phase when address bits 17:13 are all ones. It is never pulled while `refr_n` is low.
- R10: `req` is ignored in the cycle in which `done` is high, so no new address phase begins there.
- R11: A reply that arrives well inside the timeout window, even after more than a thousand cycles, completes the transfer without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, held until `done` |
| req_addr | input | 18 | Transfer address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `done` |
| timeout_err | output | 1 | Transfer aborted by timeout, valid with `done` |
| mem_err | output | 1 | Memory error reported by slave, valid with `done` |
| ad_n_in | input | 18 | Observed levels of the shared address/data lines |
| ad_n_out | output | 18 | Levels the master drives on those lines |
| ad_oe | output | 18 | Per-line drive-enable |
| astb_oe | output | 1 | Pull the address strobe low |
| rd_stb_oe | output | 1 | Pull the read strobe low |
| wr_stb_oe | output | 1 | Pull the write strobe low |
| wr_ind_oe | output | 1 | Pull the write-indicator line low |
| top_bank_oe | output | 1 | Pull the top-bank select low |
| ack_n | input | 1 | Slave reply, active-low, asynchronous |
| refr_n | input | 1 | Refresh indication, active-low |

## Verification
The properties assume that the requester keeps `req_addr`, `req_wr` and `req_wdata` steady from the rise of `req` until `done`, and that it drops `req` no later than one cycle after `done`. They also assume that the slave only replies while a data strobe is on and releases its reply only after that strobe is gone. The bench drives the requester side from a task that follows this contract. Its slave model answers only to a live strobe, releases its reply only after the strobe is removed, and never changes `refr_n` during a transfer.

// File: rtl/async_bus_master.sv
`timescale 1ns/1ps
module async_bus_master #(
  parameter int AW        = 18,
  parameter int DW        = 16,
  parameter int CLK_HZ    = 125_000_000,
  parameter int TMO_NS    = 10_000,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int BANK_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          timeout_err,
  output logic          mem_err,
  input  logic [AW-1:0] ad_n_in,
  output logic [AW-1:0] ad_n_out,
  output logic [AW-1:0] ad_oe,
  output logic          astb_oe,
  output logic          rd_stb_oe,
  output logic          wr_stb_oe,
  output logic          wr_ind_oe,
  output logic          top_bank_oe,
  input  logic          ack_n,
  input  logic          refr_n
);
  localparam int TMO_CYC = ((CLK_HZ / 1000) * TMO_NS) / 1_000_000;
  localparam int TW      = $clog2(TMO_CYC + 1);
  localparam int PH_LAST = SETUP_CYC + HOLD_CYC - 1;
  localparam int PW      = $clog2(SETUP_CYC + HOLD_CYC + 1);
  localparam int ERR_LN  = AW - 2;
  localparam int EN_LN   = AW - 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WAIT, S_REL, S_ABORT} st_t;

  st_t           st;
  logic [1:0]    ack_sync;
  logic [TW-1:0] tmo;
  logic [PW-1:0] ph;
  logic          ack_seen, busy, expired, unused_hi;

  assign ack_seen  = ~ack_sync[1];
  assign busy      = (st == S_ADDR) || (st == S_WAIT) || (st == S_REL);
  assign expired   = busy && (tmo == TW'(TMO_CYC - 1));
  assign unused_hi = ad_n_in[EN_LN];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_sync <= 2'b11;
    else        ack_sync <= {ack_sync[0], ack_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tmo         <= '0;
      ph          <= '0;
      done        <= 1'b0;
      rdata       <= '0;
      timeout_err <= 1'b0;
      mem_err     <= 1'b0;
    end else begin
      done <= 1'b0;
      tmo  <= busy ? tmo + 1'b1 : '0;
      if (expired) begin
        st <= S_ABORT;
      end else begin
        case (st)
          S_IDLE: if (req && !done) begin
            st <= S_ADDR;
            ph <= '0;
          end
          S_ADDR: if (ph == PW'(PH_LAST)) st <= S_WAIT;
                  else                     ph <= ph + 1'b1;
          S_WAIT: if (ack_seen) begin
            st      <= S_REL;
            rdata   <= req_wr ? '0 : ~ad_n_in[DW-1:0];
            mem_err <= !req_wr && !ad_n_in[ERR_LN];
          end
          S_REL: if (!ack_seen) begin
            st          <= S_IDLE;
            done        <= 1'b1;
            timeout_err <= 1'b0;
          end
          S_ABORT: begin
            st          <= S_IDLE;
            done        <= 1'b1;
            timeout_err <= 1'b1;
            rdata       <= '0;
            mem_err     <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    ad_oe    = '0;
    ad_n_out = '1;
    if (st == S_ADDR) begin
      ad_oe    = '1;
      ad_n_out = ~req_addr;
    end else if (st == S_WAIT) begin
      if (req_wr) begin
        ad_oe[DW-1:0]    = '1;
        ad_n_out[DW-1:0] = ~req_wdata;
      end else begin
        ad_oe[EN_LN]    = 1'b1;
        ad_n_out[EN_LN] = 1'b0;
      end
    end
  end

  assign astb_oe     = (st == S_ADDR && ph >= PW'(SETUP_CYC)) || st == S_WAIT || st == S_REL;
  assign rd_stb_oe   = (st == S_WAIT) && !req_wr;
  assign wr_stb_oe   = (st == S_WAIT) && req_wr;
  assign wr_ind_oe   = (st == S_ADDR) && req_wr;
  assign top_bank_oe = (st == S_ADDR) && (&req_addr[AW-1 -: BANK_BITS]) && refr_n;
endmodule

// File: rtl/async_bus_master_chk.sv
`timescale 1ns/1ps
module async_bus_master_chk #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          timeout_err,
  input logic          mem_err,
  input logic [AW-1:0] ad_oe,
  input logic [AW-1:0] ad_n_out,
  input logic          astb_oe,
  input logic          rd_stb_oe,
  input logic          wr_stb_oe,
  input logic          top_bank_oe,
  input logic          refr_n
);
  // R2
  addr_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(astb_oe) |-> (&ad_oe));
  // R3
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_oe |-> (ad_oe[DW-1:0] == '0 && ad_oe[AW-1] && !ad_n_out[AW-1]));
  // R4
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_oe |-> ((&ad_oe[DW-1:0]) && ad_oe[AW-1:DW] == '0));
  // R5
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_oe || wr_stb_oe) |-> (astb_oe && !(rd_stb_oe && wr_stb_oe)));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout_err) |-> (ad_oe == '0 && !astb_oe && !rd_stb_oe && !wr_stb_oe && !mem_err));
  // R9
  top_bank_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_bank_oe |-> refr_n);
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ad_oe == '0 && !astb_oe));
endmodule

bind async_bus_master async_bus_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .timeout_err(timeout_err), .mem_err(mem_err),
  .ad_oe(ad_oe), .ad_n_out(ad_n_out), .astb_oe(astb_oe), .rd_stb_oe(rd_stb_oe),
  .wr_stb_oe(wr_stb_oe), .top_bank_oe(top_bank_oe), .refr_n(refr_n)
);

// File: tb/async_bus_master_bench.sv
`timescale 1ns/1ps
module async_bus_master_bench;
  localparam int TMO = 1250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [17:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        done, timeout_err, mem_err;
  logic [15:0] rdata;
  logic [17:0] ad_n_in, ad_n_out, ad_oe;
  logic        astb_oe, rd_stb_oe, wr_stb_oe, wr_ind_oe, top_bank_oe;
  logic        ack_n = 1'b1;
  logic        refr_n = 1'b1;
  logic [17:0] slv_pull = '0;

  assign ad_n_in = ~((ad_oe & ~ad_n_out) | slv_pull);

  always #4 clk = ~clk;

  async_bus_master u_async_bus_master (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_wr(req_wr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .timeout_err(timeout_err),
    .mem_err(mem_err), .ad_n_in(ad_n_in), .ad_n_out(ad_n_out), .ad_oe(ad_oe),
    .astb_oe(astb_oe), .rd_stb_oe(rd_stb_oe), .wr_stb_oe(wr_stb_oe),
    .wr_ind_oe(wr_ind_oe), .top_bank_oe(top_bank_oe), .ack_n(ack_n), .refr_n(refr_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] rd;
    bit          te;
    bit          me;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [17:0] cur_addr;
  logic [15:0] cur_wdata;
  bit          cur_wr, cur_bank;
  int          s_delay;
  bit          s_merr;
  logic [15:0] s_data;

  // slave model
  bit prev_astb = 0, prev_stb = 0;
  int cnt = 0, post_cnt = 0, setup_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((&ad_oe) && !astb_oe) setup_cnt++;
      if (astb_oe && !prev_astb) begin
        chk(setup_cnt == 2, "R2", "cycles with address before strobe", setup_cnt, 2);
        chk(~ad_n_in == cur_addr, "R2", "address on lines", {14'd0, ~ad_n_in}, {14'd0, cur_addr});
        chk(wr_ind_oe == cur_wr, "R2", "write indicator", wr_ind_oe, cur_wr);
        chk(top_bank_oe == cur_bank, "R9", "top bank select", top_bank_oe, cur_bank);
        setup_cnt = 0;
      end
      if (rd_stb_oe || wr_stb_oe) begin
        if (!prev_stb) begin
          cnt = 0;
          if (rd_stb_oe)
            chk(ad_oe[15:0] == 0 && !ad_n_in[17], "R3", "read phase line use",
                {14'd0, ad_oe}, 32'h20000);
          else
            chk(~ad_n_in[15:0] == cur_wdata && ad_oe[17:16] == 0, "R4", "write data on lines",
                {14'd0, ~ad_n_in}, {16'd0, cur_wdata});
        end
        if (ack_n && s_delay >= 0 && cnt == s_delay) begin
          ack_n    = 1'b0;
          post_cnt = 0;
          slv_pull = {1'b0, s_merr, (rd_stb_oe ? s_data : 16'h0000)};
        end else if (!ack_n) begin
          post_cnt++;
        end
        cnt++;
      end else if (!ack_n) begin
        chk(post_cnt == 2, "R6", "strobe samples after reply", post_cnt, 2);
        ack_n    = 1'b1;
        slv_pull = '0;
      end
      prev_astb = astb_oe;
      prev_stb  = rd_stb_oe || wr_stb_oe;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rdata == e.rd, e.tag, "rdata", rdata, e.rd);
        chk(timeout_err == e.te, e.te ? "R7" : e.tag, "timeout_err", timeout_err, e.te);
        chk(mem_err == e.me, "R8", "mem_err", mem_err, e.me);
        if (e.te)
          chk(ad_oe == 0 && !astb_oe && !rd_stb_oe && !wr_stb_oe, "R7", "lines released after abort",
              {14'd0, ad_oe}, 0);
      end
    end
  end

  task automatic run_txn(input logic [17:0] a, input bit wr, input logic [15:0] wd,
                         input int dly, input bit me, input logic [15:0] sd,
                         input bit extra, input string tag, output int lat);
    exp_t e;
    cur_addr  = a;
    cur_wr    = wr;
    cur_wdata = wd;
    cur_bank  = (&a[17:13]) && refr_n;
    s_delay   = dly;
    s_merr    = me;
    s_data    = sd;
    e.rd  = (dly < 0 || wr) ? 16'h0000 : sd;
    e.te  = (dly < 0);
    e.me  = !wr && dly >= 0 && me;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_addr  = a;
    req_wr    = wr;
    req_wdata = wd;
    req       = 1'b1;
    lat       = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done);
    if (extra) begin
      @(negedge clk);
      chk(ad_oe == 0 && !astb_oe, "R10", "no start while done high", {14'd0, ad_oe}, 0);
      req = 1'b0;
      @(negedge clk);
      chk(ad_oe == 0 && !astb_oe, "R10", "still idle after done", {14'd0, ad_oe}, 0);
    end else begin
      req = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1
    chk(ad_oe == 0 && !astb_oe && !rd_stb_oe && !wr_stb_oe && !wr_ind_oe && !top_bank_oe && !done,
        "R1", "reset outputs", {14'd0, ad_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ad_oe == 0 && !done, "R1", "idle after reset", done, 0);

    run_txn(18'h00456, 1'b0, 16'h0000, 3, 1'b0, 16'hA5C3, 1'b0, "R3", lat);
    run_txn(18'h12345, 1'b1, 16'h5AF0, 0, 1'b0, 16'h0000, 1'b0, "R4", lat);
    run_txn(18'h00100, 1'b0, 16'h0000, 5, 1'b1, 16'h0F0F, 1'b0, "R8", lat);
    run_txn(18'h20002, 1'b1, 16'h1234, 2, 1'b1, 16'h0000, 1'b0, "R8", lat);
    refr_n = 1'b1;
    run_txn(18'h3E100, 1'b1, 16'hFFFF, 1, 1'b0, 16'h0000, 1'b0, "R9", lat);
    refr_n = 1'b0;
    run_txn(18'h3FFFE, 1'b0, 16'h0000, 4, 1'b0, 16'h8001, 1'b0, "R9", lat);
    refr_n = 1'b1;
    run_txn(18'h1E000, 1'b0, 16'h0000, 2, 1'b0, 16'h7777, 1'b0, "R5", lat);
    run_txn(18'h00200, 1'b0, 16'h0000, -1, 1'b0, 16'h0000, 1'b0, "R7", lat);
    chk(lat >= TMO && lat <= TMO + 4, "R7", "timeout latency", lat, TMO + 2);
    run_txn(18'h3FFFF, 1'b1, 16'h0001, -1, 1'b0, 16'h0000, 1'b0, "R7", lat);
    chk(lat >= TMO && lat <= TMO + 4, "R7", "timeout latency write", lat, TMO + 2);
    run_txn(18'h05555, 1'b0, 16'h0000, 1150, 1'b0, 16'hBEEF, 1'b0, "R11", lat);
    chk(lat < TMO, "R11", "slow reply completes", lat, 1160);
    run_txn(18'h0AAAA, 1'b0, 16'h0000, 0, 1'b0, 16'hC0DE, 1'b1, "R10", lat);
    run_txn(18'h00000, 1'b1, 16'hFFFF, 6, 1'b0, 16'h0000, 1'b0, "R4", lat);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule